// File: doc/BRIEF.md
# Static Memory Bus Turnaround Sequencer

This block takes one access at a time from an internal request port and runs it on an external static memory bus. It drives chip select, write enable, output enable, the external word address and a tri-state enable for the write data. A write lasts a programmable number of cycles, and a read lasts a fixed number set by a parameter. Whenever the data bus would change direction, or would pass between static memory and the dynamic memory side, the block first inserts a programmable run of idle turnaround cycles. During these cycles every strobe is inactive and the data driver is off, so two drivers never fight on the bus.

Each of four banks has its own write-length field and its own turnaround field. Both fields use an offset encoding. A request names its bank and its bank width. The block converts the byte address into the word address the memory expects. A dynamic-target request performs no static strobes. It takes part only in the turnaround decision and records that the dynamic side now owns the bus. The block raises a one-cycle done pulse at the end of every access. It accepts a new request only while it is idle. Timing fields should change only while the block is idle.

Top module: `smem_turn_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, chip select, write enable and output enable are high, the data driver enable is low, done is low and ready is high.
- R2: A static write keeps chip select low for (W + 2) cycles, where W is the 5-bit write field of the selected bank. For example, W = 31 gives 33 cycles. Write enable is low for all but the last of those cycles and is high on the last one.
- R3: A static read keeps chip select and output enable low for RD_CYCLES cycles, and write enable stays high.
- R4: When a static access follows a static access of the other direction, T + 1 idle cycles are inserted before the new access, where T is the 4-bit turnaround field of the new request's bank. For example, T = 15 gives 16 cycles.
- R5: When the target type changes between static and dynamic, in either order, T + 1 idle cycles are also inserted before the new access.
- R6: Two back-to-back accesses of the same direction and the same target type get no idle cycles between them.
- R7: During turnaround cycles chip select, write enable and output enable are high and the data driver enable is low.
- R8: The data driver enable is high only while chip select is low on a write, and the driven data equals the request's write data. Output enable and write enable are never low together.
- R9: The external address is held stable for the whole access. It is the byte address shifted right by 2 when the width code is 2'b10 or 2'b11 (32-bit), shifted right by 1 when the code is 2'b01 (16-bit), and unchanged when the code is 2'b00 (8-bit).
- R10: The write field and the turnaround field are taken from the bank that the request names. Bank b uses bits [5b+4:5b] of the write configuration and bits [4b+3:4b] of the turnaround configuration.
- R11: Done is high for exactly one cycle after each access. Ready is high only while the block is idle. A request raised while the block is busy has no effect.
- R12: A dynamic-target access occupies one cycle after any turnaround, with all static strobes high.
- R13: On a static read, the read data output shows the memory data sampled on the last read cycle, in the cycle that done is high.
- R14: The first access after reset gets no turnaround cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dyn | input | 1 | 1 = dynamic-memory target, 0 = static |
| req_bank | input | 2 | Bank select |
| req_width | input | 2 | Bank width code: 00 = 8-bit, 01 = 16-bit, 10 or 11 = 32-bit |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| cfg_waitwr | input | 5*NB | Per-bank write fields, packed by bank |
| cfg_waitturn | input | 4*NB | Per-bank turnaround fields, packed by bank |
| req_ready | output | 1 | Block is idle and will accept a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Data captured by the last static read |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | AW | External word address |
| mem_dout | output | DW | Write data toward the bus |
| mem_dout_en | output | 1 | Tri-state enable for mem_dout |
| mem_din | input | DW | Read data from the bus |

## Verification
The embedded assertions check properties that must hold on every cycle. Output enable and write enable are never low together, the data driver is on only inside a chip-select window, and write enable rises while chip select and the driver are still active. Done never lasts two cycles, the address holds through an access, and a turnaround always hands over to the access phase. The exact lengths cannot be seen from a single cycle, so only the bench scenarios show them: the (W + 2)-cycle writes, the (T + 1)-cycle gaps, the decision of when a gap is due, per-bank field selection, address scaling by width, and the read data returned with done. The bench counts these across directed corner cases and random mixes of direction, target type, bank and width.

// File: rtl/smt_pkg.sv
// Package: shared state type and width codes for the static bus sequencer.
// Assumes: width code 2'b11 is treated as a 32-bit bank.
package smt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_TURN = 2'b01,
        ST_ACC  = 2'b10
    } smt_state_e;

    localparam logic [1:0] BW_8  = 2'b00;
    localparam logic [1:0] BW_16 = 2'b01;
endpackage

// File: rtl/smt_addr_map.sv
// Module: smt_addr_map
// Converts a byte address into the external word address for the bank width.
// Assumes: purely combinational; the caller registers the result.
module smt_addr_map
    import smt_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [1:0]    width,
    input  logic [AW-1:0] byte_addr,
    output logic [AW-1:0] ext_addr
);
    // Scale the byte address by the bank width.
    always_comb begin
        case (width)
            BW_8:    ext_addr = byte_addr;
            BW_16:   ext_addr = byte_addr >> 1;
            default: ext_addr = byte_addr >> 2;
        endcase
    end
endmodule

// File: rtl/smt_turn_track.sv
// Module: smt_turn_track
// Remembers the direction and target type of the last access and decides
// whether the next access needs a turnaround. Also derives the turnaround
// length and the access length from the requesting bank's fields.
// Assumes: commit is high only in the cycle the top accepts a request.
module smt_turn_track #(
    parameter int NB        = 4,
    parameter int WW        = 5,
    parameter int TW        = 4,
    parameter int RD_CYCLES = 3,
    parameter int CW        = 7,
    localparam int BKW      = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NB*WW-1:0] cfg_waitwr,
    input  logic [NB*TW-1:0] cfg_waitturn,
    input  logic [BKW-1:0] req_bank,
    input  logic           req_write,
    input  logic           req_dyn,
    input  logic           commit,
    output logic           need_turn,
    output logic [CW-1:0]  turn_len,
    output logic [CW-1:0]  acc_len
);
    logic [WW-1:0] ww_arr [NB];
    logic [TW-1:0] tt_arr [NB];
    logic          have_last;
    logic          last_wr;
    logic          last_dyn;

    // Unpack the per-bank fields.
    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign ww_arr[b] = cfg_waitwr[b*WW +: WW];
        assign tt_arr[b] = cfg_waitturn[b*TW +: TW];
    end

    // Record the kind of each accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_last <= 1'b0;
            last_wr   <= 1'b0;
            last_dyn  <= 1'b0;
        end else if (commit) begin
            have_last <= 1'b1;
            last_wr   <= req_write;
            last_dyn  <= req_dyn;
        end
    end

    // Turnaround decision and the lengths of both phases.
    always_comb begin
        need_turn = have_last && ((last_wr != req_write) || (last_dyn != req_dyn));
        turn_len  = CW'(tt_arr[req_bank]) + CW'(1);
        if (req_dyn)
            acc_len = CW'(1);
        else if (req_write)
            acc_len = CW'(ww_arr[req_bank]) + CW'(2);
        else
            acc_len = CW'(RD_CYCLES);
    end

    // R14: no history after reset means no turnaround.
    p_first_free_r14: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !need_turn);
endmodule

// File: rtl/smem_turn_seq.sv
// Module: smem_turn_seq
// Runs one request at a time on a static memory bus. A turnaround phase of
// idle cycles comes first when the bus changes direction or target type.
// Then comes the access phase: a programmable-length write or a fixed-length
// read. A dynamic-target request has a one-cycle placeholder access.
// Assumes: configuration changes only while req_ready is high.
module smem_turn_seq
    import smt_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int NB        = 4,
    parameter int RD_CYCLES = 3,
    localparam int WW       = 5,
    localparam int TW       = 4,
    localparam int BKW      = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_dyn,
    input  logic [BKW-1:0]   req_bank,
    input  logic [1:0]       req_width,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [NB*WW-1:0] cfg_waitwr,
    input  logic [NB*TW-1:0] cfg_waitturn,
    output logic             req_ready,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    output logic             mem_cs_n,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_dout,
    output logic             mem_dout_en,
    input  logic [DW-1:0]    mem_din
);
    localparam int WR_MAX   = (1 << WW) + 1;
    localparam int TURN_MAX = 1 << TW;
    localparam int LEN_MAX  = (WR_MAX > RD_CYCLES) ? WR_MAX : RD_CYCLES;
    localparam int ALL_MAX  = (LEN_MAX > TURN_MAX) ? LEN_MAX : TURN_MAX;
    localparam int CW       = $clog2(ALL_MAX + 1) + 1;

    smt_state_e    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] acc_len_q;
    logic          cur_write;
    logic          cur_dyn;
    logic          accept;
    logic          need_turn;
    logic [CW-1:0] turn_len;
    logic [CW-1:0] acc_len;
    logic [AW-1:0] ext_addr;
    logic          in_static;

    assign accept = req_valid && (state == ST_IDLE);

    smt_addr_map #(.AW(AW)) u_map (
        .width     (req_width),
        .byte_addr (req_addr),
        .ext_addr  (ext_addr)
    );

    smt_turn_track #(
        .NB(NB), .WW(WW), .TW(TW), .RD_CYCLES(RD_CYCLES), .CW(CW)
    ) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_waitwr   (cfg_waitwr),
        .cfg_waitturn (cfg_waitturn),
        .req_bank     (req_bank),
        .req_write    (req_write),
        .req_dyn      (req_dyn),
        .commit       (accept),
        .need_turn    (need_turn),
        .turn_len     (turn_len),
        .acc_len      (acc_len)
    );

    // Phase sequencing, request capture and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            acc_len_q <= '0;
            cur_write <= 1'b0;
            cur_dyn   <= 1'b0;
            mem_addr  <= '0;
            mem_dout  <= '0;
            rd_data   <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_write <= req_write;
                        cur_dyn   <= req_dyn;
                        mem_addr  <= ext_addr;
                        mem_dout  <= req_wdata;
                        acc_len_q <= acc_len;
                        if (need_turn) begin
                            state <= ST_TURN;
                            cnt   <= turn_len;
                        end else begin
                            state <= ST_ACC;
                            cnt   <= acc_len;
                        end
                    end
                end
                ST_TURN: begin
                    if (cnt == CW'(1)) begin
                        state <= ST_ACC;
                        cnt   <= acc_len_q;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                ST_ACC: begin
                    if (cnt == CW'(1)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        if (!cur_write && !cur_dyn)
                            rd_data <= mem_din;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobe decode from the registered phase state.
    always_comb begin
        in_static   = (state == ST_ACC) && !cur_dyn;
        req_ready   = (state == ST_IDLE);
        mem_cs_n    = !in_static;
        mem_oe_n    = !(in_static && !cur_write);
        mem_we_n    = !(in_static && cur_write && (cnt != CW'(1)));
        mem_dout_en = in_static && cur_write;
    end

    // R8: read and write strobes never overlap.
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    // R8: driver only inside a write chip-select window.
    p_drive_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> (!mem_cs_n && mem_oe_n));
    // R2: write enable rises while data is still driven.
    p_we_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_cs_n && mem_dout_en));
    // R11: done is a single-cycle pulse.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11: ready only while the bus is quiet.
    p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dout_en));
    // R7: turnaround hands over to the access phase.
    p_turn_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN && cnt == CW'(1)) |=> (state == ST_ACC));
    // R9: address held through an access.
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));
endmodule

// File: tb/smem_turn_seq_bench.sv
// Bench: directed corner cases plus seeded random accesses, checked against
// lengths, gaps and addresses computed from the requirements.
module smem_turn_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NB = 4;
    localparam int RD = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_write = 1'b0;
    logic           req_dyn = 1'b0;
    logic [1:0]     req_bank = '0;
    logic [1:0]     req_width = '0;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic [NB*5-1:0] cfg_ww = '1;
    logic [NB*4-1:0] cfg_tt = '1;
    logic           req_ready, done, mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en;
    logic [DW-1:0]  rd_data, mem_dout, mem_din;
    logic [AW-1:0]  mem_addr;

    int checks = 0;
    int errors = 0;
    bit have_last = 0;
    bit last_wr = 0;
    bit last_dyn = 0;

    assign mem_din = {16'hC3C3, mem_addr};

    always #(CLK_PERIOD/2) clk = ~clk;

    smem_turn_seq #(.AW(AW), .DW(DW), .NB(NB), .RD_CYCLES(RD)) u_smem_turn_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_dyn(req_dyn), .req_bank(req_bank), .req_width(req_width),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_waitwr(cfg_ww),
        .cfg_waitturn(cfg_tt), .req_ready(req_ready), .done(done),
        .rd_data(rd_data), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    function automatic logic [AW-1:0] exp_map(input logic [1:0] w, input logic [AW-1:0] a);
        if (w == 2'b00) return a;
        if (w == 2'b01) return a >> 1;
        return a >> 2;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one access and measures it at the ports; poke raises a stray request mid-access.
    task automatic run_access(input bit wr, input bit dyn, input int bank,
                              input logic [1:0] wd, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input bit poke);
        int exp_turn, exp_len, idx, first_cs, cs_c, we_c, oe_c, de_c, bad_addr, bad_data, bad_rdy, bad_quiet;
        logic [AW-1:0] ea;
        ea = exp_map(wd, a);
        exp_turn = (have_last && (last_wr != wr || last_dyn != dyn)) ? int'(cfg_tt[bank*4 +: 4]) + 1 : 0;
        exp_len  = dyn ? 1 : (wr ? int'(cfg_ww[bank*5 +: 5]) + 2 : RD);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_dyn = dyn; req_bank = 2'(bank);
        req_width = wd; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        idx = 0; first_cs = -1; cs_c = 0; we_c = 0; oe_c = 0; de_c = 0;
        bad_addr = 0; bad_data = 0; bad_rdy = 0; bad_quiet = 0;
        while (!done && idx < 200) begin
            if (poke && idx == 1) begin
                req_valid = 1; req_write = !wr; req_addr = ~a;
            end
            if (poke && idx == 2) req_valid = 0;
            if (req_ready) bad_rdy++;
            if (!mem_cs_n) begin
                cs_c++;
                if (first_cs < 0) first_cs = idx;
                if (mem_addr != ea) bad_addr++;
            end else if (!mem_we_n || !mem_oe_n || mem_dout_en) bad_quiet++;
            if (!mem_we_n) we_c++;
            if (!mem_oe_n) oe_c++;
            if (mem_dout_en) begin
                de_c++;
                if (mem_dout != d) bad_data++;
            end
            idx++;
            @(negedge clk);
        end
        req_valid = 0;
        chk(idx == exp_turn + exp_len, "R4/R5/R6 total cycles to done", idx, exp_turn + exp_len);
        chk(bad_rdy == 0, "R11 ready low while busy", bad_rdy, 0);
        chk(bad_quiet == 0, "R7 strobes quiet outside access", bad_quiet, 0);
        if (dyn) begin
            chk(cs_c == 0, "R12 dynamic access has no static strobes", cs_c, 0);
        end else begin
            chk(first_cs == exp_turn, "R4 turnaround length", first_cs, exp_turn);
            chk(cs_c == exp_len, wr ? "R2 write cs length" : "R3 read cs length", cs_c, exp_len);
            chk(bad_addr == 0, "R9 address mapping", bad_addr, 0);
            if (wr) begin
                chk(we_c == exp_len - 1, "R2 write enable length", we_c, exp_len - 1);
                chk(de_c == exp_len && bad_data == 0, "R8 driver window and data", de_c, exp_len);
                chk(oe_c == 0, "R8 no output enable on write", oe_c, 0);
            end else begin
                chk(oe_c == exp_len && we_c == 0, "R3 read strobes", oe_c, exp_len);
                chk(de_c == 0, "R8 driver off on read", de_c, 0);
                chk(rd_data == {16'hC3C3, ea}, "R13 read data with done", rd_data, {16'hC3C3, ea});
            end
        end
        have_last = 1; last_wr = wr; last_dyn = dyn;
        @(negedge clk);
        chk(!done, "R11 done lasts one cycle", done, 0);
        if (poke) begin
            repeat (3) begin
                chk(mem_cs_n && req_ready, "R11 busy request ignored", mem_cs_n, 1);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dout_en && !done && req_ready,
            "R1 outputs during reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en, done, req_ready}, 6'b111001);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dout_en && !done && req_ready,
            "R1 outputs after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en, done, req_ready}, 6'b111001);

        // R14 and R2: first write under all-ones fields, 33 cycles, no gap.
        run_access(1, 0, 0, 2'b10, 16'h1234, 32'hDEADBEEF, 0);
        // R4: write to read gives 16 idle cycles.
        run_access(0, 0, 1, 2'b01, 16'h0F0E, '0, 0);
        // R6: read after read, no gap.
        run_access(0, 0, 3, 2'b00, 16'hABCD, '0, 0);
        // R5: static to dynamic and back.
        run_access(0, 1, 0, 2'b10, 16'h0004, '0, 0);
        run_access(0, 1, 0, 2'b10, 16'h0008, '0, 0);
        run_access(0, 0, 2, 2'b11, 16'hFFFF, '0, 0);
        // R10: bank 2 with smallest fields, other banks left at maximum.
        cfg_ww[2*5 +: 5] = 5'd0;
        cfg_tt[2*4 +: 4] = 4'd0;
        run_access(1, 0, 2, 2'b00, 16'h00FF, 32'h0BADF00D, 0);
        run_access(0, 0, 2, 2'b01, 16'h8001, '0, 0);
        run_access(0, 0, 1, 2'b10, 16'h7777, '0, 1);

        for (int i = 0; i < 300; i++) begin
            bit wr, dyn;
            int bank;
            if ($urandom_range(0, 9) == 0) begin
                int b2;
                b2 = $urandom_range(0, NB-1);
                cfg_ww[b2*5 +: 5] = ($urandom_range(0, 7) == 0) ? 5'd31 : 5'($urandom_range(0, 6));
                cfg_tt[b2*4 +: 4] = 4'($urandom_range(0, 15));
            end
            wr   = $urandom_range(0, 1) == 1;
            dyn  = $urandom_range(0, 4) == 0;
            bank = $urandom_range(0, NB-1);
            run_access(wr, dyn, bank, 2'($urandom_range(0, 3)), 16'($urandom),
                       $urandom, $urandom_range(0, 15) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule